// File: doc/BRIEF.md
# Reservation Table Collision Analyzer

This block takes the occupancy table of a multi-stage pipeline, one busy row per stage with one bit per time column. It works out which initiation latencies are unsafe. A latency is unsafe when a second initiation started that many cycles after a first one would need some stage in a time slot the first still holds. To find these, the block slides the table against a copy of itself, one latency per clock. The results are a collision vector and two masks: a forbidden mask and a permissible mask. The permissible mask is the complement of the forbidden one.

A scheduler or a configuration checker pulses `load` with the table on `table_in`. The block then sweeps latencies 1 to COLS-1 and marks the end with a one-cycle `done` pulse. The outputs stay valid until the next load. Latencies of COLS or more can never collide, so they are not examined. A load that arrives during a sweep drops the sweep in progress and starts again on the new table.

Top module: `resv_collision_analyzer`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `coll_vec` is all zeros.
- R2: `table_in` holds STAGES rows of COLS bits. Row s sits at bits [s*COLS +: COLS], and bit t of a row means that stage is occupied at time t+1. The table is captured on the clock edge where `load` is 1.
- R3: Bit i of `coll_vec` (index range COLS-1 down to 1) is 1 exactly when some stage has both bit t and bit t+i of its row set, for some t.
- R4: `forbid_mask` is COLS bits wide. Bit 0 is 1 exactly when the table has any bit set, and bits COLS-1..1 equal `coll_vec`. `permit_mask` is the bitwise inverse of `forbid_mask`.
- R5: `busy` is 1 from the edge after the load edge until the sweep ends. `done` is 1 for exactly one cycle, starting COLS-1 edges after the load edge, and `busy` is 0 in that cycle.
- R6: A `load` during a sweep restarts the analysis on the new table. No `done` is given for the abandoned sweep, and the next `done` comes COLS-1 edges after the latest load.
- R7: After `done`, the three result outputs stay unchanged until the next `load`.
- R8: For the 3-stage, 8-column table with stage 1 busy at times 1, 6, 8, stage 2 busy at times 2, 4, and stage 3 busy at times 3, 5, 7, `coll_vec` is 1011010 (bit 7 down to bit 1).
- R9: An empty table gives an all-zero `forbid_mask`. A table with one occupied column per stage gives `coll_vec` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture `table_in` and start a sweep |
| table_in | input | STAGES*COLS | Occupancy table, one row per stage |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse marking the end of a sweep |
| coll_vec | output | COLS-1 | Collision vector, bit i for latency i |
| forbid_mask | output | COLS | Forbidden latencies, 0 to COLS-1 |
| permit_mask | output | COLS | Permissible latencies, 0 to COLS-1 |

## Verification
Each latency writes exactly one bit of the vector on its own sweep edge. A wrong latency counter therefore shows up as a misplaced or missing bit, or as a `done` that arrives at the wrong cycle. Both are visible at the first `done` after a load, which is COLS-1 cycles later. A stale captured table or a vector that was not cleared shows up at the `done` after a restarting load, as bits carried over from the older table. Hold checks several cycles after `done` expose any write that escapes the sweep window.

// File: rtl/rca_pkg.sv
// Package: shared types for the collision analyzer.
// Assumes: nothing beyond IEEE 1800-2017.
package rca_pkg;
    typedef enum logic {
        SWP_IDLE = 1'b0,
        SWP_RUN  = 1'b1
    } sweep_state_t;
endpackage

// File: rtl/rca_shift_match.sv
// Module: rca_shift_match
// Purpose: combinational test of whether one latency collides. Each stage
// row is ANDed with itself shifted down by the latency, and the results of
// all stages are ORed together.
// Assumes: lat lies in 1..COLS-1; row s is at bits [s*COLS +: COLS].
module rca_shift_match #(
    parameter int STAGES = 3,
    parameter int COLS   = 8,
    localparam int LAT_W = $clog2(COLS)
) (
    input  logic [STAGES*COLS-1:0] tbl,
    input  logic [LAT_W-1:0]       lat,
    output logic                   hit
);
    logic [STAGES-1:0] row_hit;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_row
            logic [COLS-1:0] row;
            // Overlap of one stage's row with its own shifted copy.
            always_comb begin
                row        = tbl[s*COLS +: COLS];
                row_hit[s] = |(row & (row >> lat));
            end
        end
    endgenerate

    // Any overlapping stage makes the latency forbidden.
    always_comb hit = |row_hit;
endmodule

// File: rtl/rca_sweep_ctrl.sv
// Module: rca_sweep_ctrl
// Purpose: walks the latency counter from 1 to COLS-1, one step per clock,
// and pulses done after the last step. A load restarts it at any time.
// Assumes: COLS >= 2; synchronous active-low reset.
module rca_sweep_ctrl
    import rca_pkg::*;
#(
    parameter int COLS   = 8,
    localparam int LAT_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic             step,
    output logic [LAT_W-1:0] lat,
    output logic             busy,
    output logic             done
);
    localparam logic [LAT_W-1:0] LAT_LAST  = LAT_W'(COLS - 1);
    localparam logic [LAT_W-1:0] LAT_FIRST = LAT_W'(1);

    sweep_state_t state;

    // Sweep state, latency counter and end-of-sweep pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SWP_IDLE;
            lat   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state <= SWP_RUN;
                lat   <= LAT_FIRST;
            end else if (state == SWP_RUN) begin
                if (lat == LAT_LAST) begin
                    state <= SWP_IDLE;
                    lat   <= '0;
                    done  <= 1'b1;
                end else begin
                    lat <= lat + 1'b1;
                end
            end
        end
    end

    // Each running cycle evaluates one latency.
    always_comb begin
        busy = (state == SWP_RUN);
        step = busy && !load;
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6
    load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && !done && lat == LAT_FIRST));
    // R3
    lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat >= LAT_FIRST && lat <= LAT_LAST));
endmodule

// File: rtl/resv_collision_analyzer.sv
// Module: resv_collision_analyzer
// Purpose: top level. Captures a reservation table, sweeps every latency
// from 1 to COLS-1 through the shift matcher, and builds the collision
// vector and the forbidden and permissible masks.
// Assumes: STAGES >= 1, COLS >= 2; synchronous active-low reset.
module resv_collision_analyzer #(
    parameter int STAGES = 3,
    parameter int COLS   = 8,
    localparam int LAT_W = $clog2(COLS),
    localparam int TBL_W = STAGES * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TBL_W-1:0] table_in,
    output logic             busy,
    output logic             done,
    output logic [COLS-1:1]  coll_vec,
    output logic [COLS-1:0]  forbid_mask,
    output logic [COLS-1:0]  permit_mask
);
    logic [TBL_W-1:0] tbl_q;
    logic             zero_q;
    logic [COLS-1:1]  vec_q;
    logic             step;
    logic [LAT_W-1:0] lat;
    logic             hit;

    rca_sweep_ctrl #(.COLS(COLS)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .step (step),
        .lat  (lat),
        .busy (busy),
        .done (done)
    );

    rca_shift_match #(.STAGES(STAGES), .COLS(COLS)) u_match (
        .tbl(tbl_q),
        .lat(lat),
        .hit(hit)
    );

    // Table capture, latency-0 flag and per-latency vector writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q  <= '0;
            zero_q <= 1'b0;
            vec_q  <= '0;
        end else if (load) begin
            tbl_q  <= table_in;
            zero_q <= |table_in;
            vec_q  <= '0;
        end else if (step) begin
            vec_q[lat] <= hit;
        end
    end

    // Result outputs.
    always_comb begin
        coll_vec    = vec_q;
        forbid_mask = {vec_q, zero_q};
        permit_mask = ~forbid_mask;
    end

    // R7
    hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(vec_q));
    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (vec_q == '0));
endmodule

// File: tb/tb_resv_collision_analyzer.sv
module tb_resv_collision_analyzer;
    localparam int STAGES = 3;
    localparam int COLS   = 8;
    localparam int TBL_W  = STAGES * COLS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load = 1'b0;
    logic [TBL_W-1:0] table_in = '0;
    logic             busy, done;
    logic [COLS-1:1]  coll_vec;
    logic [COLS-1:0]  forbid_mask, permit_mask;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #2 clk = ~clk;  // 250 MHz

    resv_collision_analyzer #(.STAGES(STAGES), .COLS(COLS)) dut (
        .clk(clk), .rst_n(rst_n), .load(load), .table_in(table_in),
        .busy(busy), .done(done), .coll_vec(coll_vec),
        .forbid_mask(forbid_mask), .permit_mask(permit_mask)
    );

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model from R3/R4: latency i collides if a row overlaps its shift by i.
    function automatic logic [COLS-1:0] ref_forbid(input logic [TBL_W-1:0] t);
        logic [COLS-1:0] f = '0;
        f[0] = |t;
        for (int i = 1; i < COLS; i++)
            for (int s = 0; s < STAGES; s++)
                for (int c = 0; c + i < COLS; c++)
                    if (t[s*COLS + c] && t[s*COLS + c + i]) f[i] = 1'b1;
        return f;
    endfunction

    // Load at a negedge, then follow the sweep edge by edge (R5).
    task automatic run_table(input logic [TBL_W-1:0] t, input string req);
        logic [COLS-1:0] exp_f;
        exp_f = ref_forbid(t);
        load = 1'b1; table_in = t;
        @(negedge clk); load = 1'b0;
        for (int k = 1; k <= COLS; k++) begin
            if (k > 1) @(negedge clk);
            if (k < COLS) begin
                chk(busy && !done, "R5 busy during sweep", {busy, done}, 2'b10);
            end else begin
                chk(done && !busy, "R5 done timing", {busy, done}, 2'b01);
            end
        end
        chk(coll_vec == exp_f[COLS-1:1], {req, " R3 coll_vec"}, coll_vec, exp_f[COLS-1:1]);
        chk(forbid_mask == exp_f, "R4 forbid_mask", forbid_mask, exp_f);
        chk(permit_mask == ~exp_f, "R4 permit_mask", permit_mask, ~exp_f);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(!busy && !done && coll_vec == '0, "R1 reset state", {busy, done, coll_vec}, 0);
    endtask

    task automatic test_example();
        // S1 times 1,6,8 = 0xA1; S2 times 2,4 = 0x0A; S3 times 3,5,7 = 0x54
        run_table(24'h540AA1, "R8");
        chk(coll_vec == 7'b1011010, "R8 worked example", coll_vec, 7'b1011010);
        chk(forbid_mask == 8'hB5, "R8 forbid", forbid_mask, 8'hB5);
    endtask

    task automatic test_patterns();
        run_table('0, "R9 empty");
        chk(forbid_mask == 8'h00, "R9 empty table", forbid_mask, 8'h00);
        run_table(24'h800201, "R9 single column");
        chk(coll_vec == '0, "R9 one column per stage", coll_vec, 0);
        run_table(24'hFFFFFF, "R2 full");
        run_table(24'h000081, "R2 row0 ends");
        run_table(24'h030000, "R2 row2 adjacent");
        run_table(24'h112244, "R3 mixed");
    endtask

    task automatic test_hold();
        logic [COLS-1:0] f;
        run_table(24'h540AA1, "R7 setup");
        f = forbid_mask;
        repeat (5) @(negedge clk);
        chk(forbid_mask == f && !done && !busy, "R7 hold after done", forbid_mask, f);
    endtask

    task automatic test_restart();
        logic [TBL_W-1:0] b;
        logic [COLS-1:0]  exp_f;
        int               seen;
        b = 24'h000011;  // stage 1 busy at times 1 and 5: only latency 4 forbidden
        exp_f = ref_forbid(b);
        load = 1'b1; table_in = 24'hFFFFFF;
        @(negedge clk); load = 1'b0;
        @(negedge clk); @(negedge clk);
        load = 1'b1; table_in = b;
        @(negedge clk); load = 1'b0;
        seen = 0;
        for (int k = 1; k <= COLS; k++) begin
            if (k > 1) @(negedge clk);
            if (done) seen = k;
        end
        chk(seen == COLS, "R6 done after latest load", seen, COLS);
        chk(forbid_mask == exp_f, "R6 restart result", forbid_mask, exp_f);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_example();
        test_patterns();
        test_hold();
        test_restart();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule